// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is an SPI master that carries out single-byte reads and single-byte writes on a serial EEPROM that takes a 16-bit address. The host presents a request with a direction flag, an address and a data byte. For a read, the block sends one framed transfer and returns the byte it receives. For a write, the block runs a fixed series of frames without further host involvement. It first reads the device status and checks the target address against the block-protect field. It then sets the write-enable latch in a frame of its own and sends the write frame. Last, it keeps polling the status until the internal programming cycle ends.

Each command has its own chip-select window. The serial clock is the system clock divided by a parameter and idles low. The bus runs in SPI mode 0, most significant bit first. A write to a protected address is refused before any write-enable is sent. A programming cycle that never ends is cut off by a poll limit. Both outcomes are reported on error flags that come with the completion pulse.

Top module: `eeprom_spi_ctrl`

## Requirements
- R1: While reset is held and after it is released, chip select is high, the serial clock is low, the request-ready output is high and the completion pulse is low.
- R2: A read sends opcode 0x03, the address high byte and the address low byte, then clocks in one byte, all inside one chip-select window. Bits go out and come in most significant first. The output changes on the falling clock edge and the input is sampled on the rising edge. The received byte appears on the read-data output when the completion pulse is high.
- R3: A write that is allowed produces four frames, each with its own chip-select window, in this order: read-status (0x05 followed by one received byte), write-enable (0x06 alone), write (0x02, address high, address low, data), then the first status poll (0x05).
- R4: The block-protect code is status bits 3:2 (bit 0 is busy, bit 1 is the write-enable latch). Code 00 protects nothing. Code 01 protects 0x6000 to 0x7FFF. Code 10 protects 0x4000 to 0x7FFF. Code 11 protects 0x0000 to 0x7FFF. Addresses from 0x8000 upward are never protected.
- R5: A write to a protected address ends after the status frame, with the protect-error flag high. No write-enable or write frame is sent, and the memory contents do not change.
- R6: After the write frame, the block repeats read-status frames until a returned status has bit 0 at 0, and then pulses completion. If the device reads busy N times, there are N+1 polls.
- R7: If POLL_LIMIT polls in a row all read busy, the block stops polling and pulses completion with the timeout-error flag high. If the device reads busy only POLL_LIMIT-1 times, the write finishes with no error.
- R8: Between two chip-select windows, chip select stays high for at least 2*HALF_DIV system clocks, which is one serial clock period. The serial clock is low whenever chip select is high.
- R9: A request is accepted only while request-ready is high. A request raised while a transaction is in progress is ignored and causes no bus activity.
- R10: Completion is a pulse of one cycle. The error flags and read data keep their values until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqAddr | input | 16 | Byte address |
| reqData | input | 8 | Byte to write |
| reqReady | output | 1 | High when idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| errProt | output | 1 | Write refused because the address is protected |
| errTimeout | output | 1 | Busy flag never cleared within the poll limit |
| rdData | output | 8 | Byte returned by the last read |
| spiCsN | output | 1 | Active-low chip select |
| spiSck | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the memory |
| spiMiso | input | 1 | Serial data from the memory |

## Verification
If the frame selector or byte index holds a wrong value, the opcode sequence on the bus is wrong from the next chip-select window on. The logged opcode order and the per-command counts expose this within one transaction. A bad shift or sample phase corrupts every byte, so it shows as wrong read-back data on the first read. A faulty protect decode or poll counter does not disturb the bus framing. It shows only as a wrong error flag, a wrong memory value on read-back, or a poll count that is one off, so the bench sweeps every protect code against addresses on both sides of each boundary and tries busy durations on either side of the poll limit.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // strobes from the sequencer to the shift engine
  typedef struct packed {
    logic       csLow;
    logic       csHigh;
    logic       byteStart;
    logic       gapStart;
    logic [7:0] txByte;
  } spiStrobe_t;

  typedef enum logic [2:0] {
    FR_CHECK,
    FR_WREN,
    FR_WRITE,
    FR_POLL,
    FR_READ
  } frame_e;

  // true when the block-protect code covers the address
  function automatic logic isProtected(input logic [1:0] bp, input logic [15:0] addr);
    logic inArray;
    inArray = (addr <= 16'h7FFF);
    case (bp)
      2'b01:   isProtected = inArray && (addr >= 16'h6000);
      2'b10:   isProtected = inArray && (addr >= 16'h4000);
      2'b11:   isProtected = inArray;
      default: isProtected = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eeprom_spi_datapath.sv
module eeprom_spi_datapath
  import eeprom_spi_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  spiStrobe_t strb,
  input  logic       spiMiso,
  output logic       byteDone,
  output logic       gapDone,
  output logic [7:0] rxByte,
  output logic       spiCsN,
  output logic       spiSck,
  output logic       spiMosi
);

  localparam int CW = $clog2(2 * HALF_DIV + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GAP_LEN   = CW'(2 * HALF_DIV);

  logic          csN;
  logic          sck;
  logic [7:0]    shReg;
  logic          sampleBit;
  logic [2:0]    bitCnt;
  logic          active;
  logic [CW-1:0] halfCnt;
  logic [CW-1:0] gapCnt;
  logic          byteDoneR;
  logic          gapDoneR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN       <= 1'b1;
      sck       <= 1'b0;
      shReg     <= '0;
      sampleBit <= 1'b0;
      bitCnt    <= '0;
      active    <= 1'b0;
      halfCnt   <= '0;
      gapCnt    <= '0;
      byteDoneR <= 1'b0;
      gapDoneR  <= 1'b0;
    end else begin
      byteDoneR <= 1'b0;
      gapDoneR  <= 1'b0;

      if (strb.csLow) csN <= 1'b0;
      else if (strb.csHigh) csN <= 1'b1;

      if (strb.byteStart && !active) begin
        shReg   <= strb.txByte;
        bitCnt  <= '0;
        halfCnt <= '0;
        active  <= 1'b1;
        sck     <= 1'b0;
      end else if (active) begin
        if (halfCnt == HALF_LAST) begin
          halfCnt <= '0;
          if (!sck) begin
            // rising edge: capture the incoming bit
            sck       <= 1'b1;
            sampleBit <= spiMiso;
          end else begin
            // falling edge: advance the outgoing bit
            sck    <= 1'b0;
            shReg  <= {shReg[6:0], sampleBit};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              active    <= 1'b0;
              byteDoneR <= 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end

      if (strb.gapStart) gapCnt <= GAP_LEN;
      else if (gapCnt != '0) begin
        gapCnt <= gapCnt - 1'b1;
        if (gapCnt == CW'(1)) gapDoneR <= 1'b1;
      end
    end
  end

  assign byteDone = byteDoneR;
  assign gapDone  = gapDoneR;
  assign rxByte   = shReg;
  assign spiCsN   = csN;
  assign spiSck   = sck;
  assign spiMosi  = shReg[7];

  // R8: clock stays parked low outside a chip-select window
  a_r8_sck_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

  // R8: a byte is never clocked while the memory is deselected
  a_r8_shift_inside_window: assert property (@(posedge clk) disable iff (!rstN)
    active |-> !spiCsN);

  // R2: outgoing data is steady across each rising edge
  a_r2_mosi_steady_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSck) |-> $stable(spiMosi));

endmodule

// File: rtl/eeprom_spi_control.sv
module eeprom_spi_control
  import eeprom_spi_pkg::*;
#(
  parameter int POLL_LIMIT = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqData,
  output logic        reqReady,
  output logic        done,
  output logic        errProt,
  output logic        errTimeout,
  output logic [7:0]  rdData,
  output spiStrobe_t  strb,
  input  logic        byteDone,
  input  logic        gapDone,
  input  logic [7:0]  rxByte
);

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CS_ON, ST_XFER, ST_GAP} state_e;

  state_e        state;
  frame_e        frame;
  logic [2:0]    idx;
  logic [15:0]   addrR;
  logic [7:0]    dataR;
  logic [7:0]    rxLast;
  logic [PW-1:0] pollCnt;
  logic          doneR;
  logic          errProtR;
  logic          errToR;
  logic [7:0]    rdDataR;

  function automatic logic [2:0] frameLen(input frame_e f);
    case (f)
      FR_WREN:           frameLen = 3'd1;
      FR_CHECK, FR_POLL: frameLen = 3'd2;
      default:           frameLen = 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] txFor(input frame_e f, input logic [2:0] i,
                                       input logic [15:0] a, input logic [7:0] d);
    logic [7:0] op;
    case (f)
      FR_WREN:           op = OP_WREN;
      FR_WRITE:          op = OP_WRITE;
      FR_READ:           op = OP_READ;
      default:           op = OP_RDSR;
    endcase
    case (i)
      3'd0:    txFor = op;
      3'd1:    txFor = (f == FR_WRITE || f == FR_READ) ? a[15:8] : 8'h00;
      3'd2:    txFor = a[7:0];
      3'd3:    txFor = (f == FR_WRITE) ? d : 8'h00;
      default: txFor = 8'h00;
    endcase
  endfunction

  always_comb begin
    strb = '0;
    case (state)
      ST_CS_ON: begin
        strb.csLow     = 1'b1;
        strb.byteStart = 1'b1;
        strb.txByte    = txFor(frame, 3'd0, addrR, dataR);
      end
      ST_XFER: begin
        if (byteDone) begin
          if (idx < frameLen(frame)) begin
            strb.byteStart = 1'b1;
            strb.txByte    = txFor(frame, idx, addrR, dataR);
          end else begin
            strb.csHigh   = 1'b1;
            strb.gapStart = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      frame    <= FR_READ;
      idx      <= '0;
      addrR    <= '0;
      dataR    <= '0;
      rxLast   <= '0;
      pollCnt  <= '0;
      doneR    <= 1'b0;
      errProtR <= 1'b0;
      errToR   <= 1'b0;
      rdDataR  <= '0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            addrR    <= reqAddr;
            dataR    <= reqData;
            errProtR <= 1'b0;
            errToR   <= 1'b0;
            pollCnt  <= '0;
            frame    <= reqWrite ? FR_CHECK : FR_READ;
            state    <= ST_CS_ON;
          end
        end
        ST_CS_ON: begin
          idx   <= 3'd1;
          state <= ST_XFER;
        end
        ST_XFER: begin
          if (byteDone) begin
            if (idx < frameLen(frame)) idx <= idx + 3'd1;
            else begin
              rxLast <= rxByte;
              state  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gapDone) begin
            state <= ST_CS_ON;
            case (frame)
              FR_CHECK: begin
                if (isProtected(rxLast[3:2], addrR)) begin
                  errProtR <= 1'b1;
                  doneR    <= 1'b1;
                  state    <= ST_IDLE;
                end else begin
                  frame <= FR_WREN;
                end
              end
              FR_WREN:  frame <= FR_WRITE;
              FR_WRITE: frame <= FR_POLL;
              FR_POLL: begin
                if (!rxLast[0]) begin
                  doneR <= 1'b1;
                  state <= ST_IDLE;
                end else if (pollCnt == POLL_LAST) begin
                  errToR <= 1'b1;
                  doneR  <= 1'b1;
                  state  <= ST_IDLE;
                end else begin
                  pollCnt <= pollCnt + 1'b1;
                end
              end
              default: begin
                rdDataR <= rxLast;
                doneR   <= 1'b1;
                state   <= ST_IDLE;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign done       = doneR;
  assign errProt    = errProtR;
  assign errTimeout = errToR;
  assign rdData     = rdDataR;

  // R10: completion lasts exactly one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a transaction ends with at most one kind of error
  a_r7_errors_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(errProt && errTimeout));

  // R9: captured request stays fixed while a transaction runs
  a_r9_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> ($stable(addrR) && $stable(dataR)));

  // R5: a refused write starts no byte until a new request
  a_r5_refusal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    errProt |-> !strb.byteStart);

  // R7: the poll counter never passes the limit
  a_r7_poll_bounded: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PW'(POLL_LIMIT));

endmodule

// File: rtl/eeprom_spi_ctrl.sv
module eeprom_spi_ctrl
  import eeprom_spi_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int POLL_LIMIT = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqData,
  output logic        reqReady,
  output logic        done,
  output logic        errProt,
  output logic        errTimeout,
  output logic [7:0]  rdData,
  output logic        spiCsN,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso
);

  spiStrobe_t strb;
  logic       byteDone;
  logic       gapDone;
  logic [7:0] rxByte;

  eeprom_spi_control #(.POLL_LIMIT(POLL_LIMIT)) ctl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData),
    .reqReady(reqReady), .done(done), .errProt(errProt), .errTimeout(errTimeout),
    .rdData(rdData), .strb(strb),
    .byteDone(byteDone), .gapDone(gapDone), .rxByte(rxByte)
  );

  eeprom_spi_datapath #(.HALF_DIV(HALF_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .spiMiso(spiMiso),
    .byteDone(byteDone), .gapDone(gapDone), .rxByte(rxByte),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi)
  );

endmodule

// File: tb/eeprom_spi_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_spi_ctrl_tb_top;

  localparam int HALF = 2;
  localparam int PLIM = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        reqReady, done, errProt, errTimeout;
  logic [7:0]  rdData;
  logic        spiCsN, spiSck, spiMosi;
  logic        misoR = 1'b0;

  always #2.5 clk = ~clk;

  eeprom_spi_ctrl #(.HALF_DIV(HALF), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady), .done(done),
    .errProt(errProt), .errTimeout(errTimeout), .rdData(rdData),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(misoR)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [1:0] bpCode = 2'b00;
  logic       wel = 1'b0;
  int         busyLeft = 0;
  int         busySet = 0;
  int         bitN = 0, byteN = 0;
  logic [7:0] inSh = '0, opcode = '0, aHi = '0, aLo = '0, dIn = '0, outSh = '0;
  int wrenCnt = 0, writeCnt = 0, rdsrCnt = 0, readCnt = 0;
  logic [7:0] opLog [16];
  int opN = 0;

  function automatic int idxOf(input logic [15:0] a);
    return int'({a[15:12], a[3:0]});
  endfunction

  function automatic logic [7:0] statusNow();
    return {4'b0000, bpCode, wel, (busyLeft != 0)};
  endfunction

  always @(negedge spiCsN) begin
    bitN = 0;
    byteN = 0;
  end

  always @(posedge spiSck) if (spiCsN === 1'b0) begin
    inSh = {inSh[6:0], spiMosi};
    bitN++;
    if (bitN == 8) begin
      bitN = 0;
      case (byteN)
        0: opcode = inSh;
        1: aHi = inSh;
        2: aLo = inSh;
        3: dIn = inSh;
        default: ;
      endcase
      byteN++;
      if (byteN == 1 && inSh == 8'h05) outSh = statusNow();
      if (byteN == 3 && opcode == 8'h03) outSh = mem[idxOf({aHi, aLo})];
    end
  end

  always @(negedge spiSck) if (spiCsN === 1'b0) begin
    misoR = outSh[7];
    outSh = {outSh[6:0], 1'b0};
  end

  always @(posedge spiCsN) if (byteN > 0) begin
    if (opN < 16) opLog[opN] = opcode;
    opN++;
    case (opcode)
      8'h06: if (byteN == 1) begin wel = 1'b1; wrenCnt++; end
      8'h02: if (byteN == 4) begin
        writeCnt++;
        if (wel) mem[idxOf({aHi, aLo})] = dIn;
        wel = 1'b0;
        busyLeft = busySet;
      end
      8'h05: begin rdsrCnt++; if (busyLeft > 0) busyLeft--; end
      8'h03: readCnt++;
      default: ;
    endcase
    byteN = 0;
  end

  // ---------------- bus monitors (R8, R10) ----------------
  int hiRun = 0, gapViol = 0, sckViol = 0, donePrev = 0, doneViol = 0;
  bit seenFrame = 0;
  always @(negedge clk) if (rstN) begin
    if (spiCsN) hiRun++;
    else begin
      if (seenFrame && hiRun > 0 && hiRun < 2 * HALF) gapViol++;
      hiRun = 0;
      seenFrame = 1;
    end
    if (spiCsN && spiSck) sckViol++;
    if (done && donePrev != 0) doneViol++;
    donePrev = done ? 1 : 0;
  end

  // ---------------- stimulus helpers ----------------
  task automatic runOp(input bit wr, input logic [15:0] a, input logic [7:0] d, output bit ok);
    int w;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    ok = done;
    if (!ok) check(1'b0, "watchdog op", 0, 1);
  endtask

  function automatic bit expProt(input logic [1:0] bp, input logic [15:0] a);
    if (a > 16'h7FFF) return 0;
    if (bp == 2'b11) return 1;
    if (bp == 2'b10) return a >= 16'h4000;
    if (bp == 2'b01) return a >= 16'h6000;
    return 0;
  endfunction

  function automatic logic [15:0] sweepAddr(input int k);
    case (k)
      0: return 16'h0000; 1: return 16'h3FFF; 2: return 16'h4000; 3: return 16'h5FFF;
      4: return 16'h6000; 5: return 16'h7FFF; 6: return 16'h8000; default: return 16'hFFFF;
    endcase
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog global", 0, 1);
    finish();
  end

  initial begin
    bit ok;
    int r0, w0, e0, n0, rd0;
    logic [15:0] a;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 37) ^ 8'h5A);
      shadow[i] = mem[i];
    end

    repeat (4) @(negedge clk);
    // R1: values during reset
    check(spiCsN == 1'b1 && spiSck == 1'b0, "R1 bus in reset", {spiCsN, spiSck}, 2'b10);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(spiCsN == 1'b1, "R1 cs after reset", spiCsN, 1);
    check(spiSck == 1'b0, "R1 sck after reset", spiSck, 0);
    check(reqReady == 1'b1, "R1 ready", reqReady, 1);
    check(done == 1'b0, "R1 done low", done, 0);

    // R2: reads of several patterns
    for (int k = 0; k < 8; k++) begin
      a = 16'((k * 16'h2345) ^ 16'h0F0F);
      rd0 = readCnt;
      n0 = opN;
      runOp(1'b0, a, 8'h00, ok);
      check(rdData == shadow[idxOf(a)], "R2 read data", rdData, shadow[idxOf(a)]);
      check(readCnt == rd0 + 1 && opN == n0 + 1, "R2 single read frame", readCnt - rd0, 1);
    end

    // R3 / R6: plain write with three busy reads
    busySet = 3;
    n0 = opN; r0 = rdsrCnt;
    runOp(1'b1, 16'h0102, 8'h3C, ok);
    shadow[idxOf(16'h0102)] = 8'h3C;
    check(opLog[n0] == 8'h05, "R3 first frame status", opLog[n0], 8'h05);
    check(opLog[n0+1] == 8'h06, "R3 second frame wren", opLog[n0+1], 8'h06);
    check(opLog[n0+2] == 8'h02, "R3 third frame write", opLog[n0+2], 8'h02);
    check(opLog[n0+3] == 8'h05, "R3 fourth frame poll", opLog[n0+3], 8'h05);
    check(rdsrCnt - r0 == 1 + 4, "R6 poll count", rdsrCnt - r0, 5);
    check(!errProt && !errTimeout, "R6 no error", {errProt, errTimeout}, 0);
    runOp(1'b0, 16'h0102, 8'h00, ok);
    check(rdData == 8'h3C, "R2 read back", rdData, 8'h3C);

    // R4 / R5: every protect code against boundary addresses
    busySet = 1;
    for (int bp = 0; bp < 4; bp++) begin
      bpCode = 2'(bp);
      for (int k = 0; k < 8; k++) begin
        bit p;
        a = sweepAddr(k);
        d = 8'((bp * 8 + k) * 29 + 3);
        p = expProt(2'(bp), a);
        w0 = writeCnt; e0 = wrenCnt;
        runOp(1'b1, a, d, ok);
        if (!p) shadow[idxOf(a)] = d;
        check(errProt == p, "R4 protect decision", errProt, p);
        check((writeCnt - w0) == (p ? 0 : 1) && (wrenCnt - e0) == (p ? 0 : 1),
              "R5 frames sent", writeCnt - w0, p ? 0 : 1);
        runOp(1'b0, a, 8'h00, ok);
        check(rdData == shadow[idxOf(a)], "R5 memory contents", rdData, shadow[idxOf(a)]);
      end
    end
    bpCode = 2'b00;

    // R7: busy just under the limit succeeds
    busySet = PLIM - 1;
    r0 = rdsrCnt;
    runOp(1'b1, 16'h0203, 8'h77, ok);
    shadow[idxOf(16'h0203)] = 8'h77;
    check(!errTimeout, "R7 under limit no timeout", errTimeout, 0);
    check(rdsrCnt - r0 == 1 + PLIM, "R7 under limit polls", rdsrCnt - r0, 1 + PLIM);

    // R7: busy at the limit times out
    busySet = PLIM;
    r0 = rdsrCnt;
    runOp(1'b1, 16'h0304, 8'h88, ok);
    shadow[idxOf(16'h0304)] = 8'h88;
    check(errTimeout == 1'b1, "R7 timeout flag", errTimeout, 1);
    check(rdsrCnt - r0 == 1 + PLIM, "R7 timeout polls", rdsrCnt - r0, 1 + PLIM);
    repeat (30) @(negedge clk);
    check(errTimeout == 1'b1 && done == 1'b0, "R10 flag held", errTimeout, 1);
    check(rdsrCnt - r0 == 1 + PLIM, "R7 no poll after timeout", rdsrCnt - r0, 1 + PLIM);
    busyLeft = 0;

    // R9: request while busy is ignored
    busySet = 2;
    rd0 = readCnt;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0405; reqData = 8'h99;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (20) @(negedge clk);
    check(reqReady == 1'b0, "R9 not ready while busy", reqReady, 0);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h0506;
    @(negedge clk);
    reqValid = 1'b0;
    begin
      int w = 0;
      while (!done && w < 20000) begin @(negedge clk); w++; end
    end
    shadow[idxOf(16'h0405)] = 8'h99;
    n0 = opN;
    repeat (200) @(negedge clk);
    check(readCnt == rd0 && opN == n0, "R9 ignored request", readCnt - rd0, 0);
    check(spiCsN == 1'b1 && reqReady == 1'b1, "R9 idle afterwards", spiCsN, 1);

    // R8 / R10: bus monitors
    check(gapViol == 0, "R8 chip-select gap", gapViol, 0);
    check(sckViol == 0, "R8 sck low when deselected", sckViol, 0);
    check(doneViol == 0, "R10 single-cycle done", doneViol, 0);
    finish();
  end

endmodule